// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Sequencer

This block is the control unit and register set of a small accumulator machine. It walks each instruction through explicit register-transfer steps. Fetch moves the program counter into the address register, reads memory, captures the word into the buffer register and then into the instruction register. An optional indirect step replaces the operand address with a pointer word read from memory. A short execute step handles load, add, store, jump and the two interrupt-enable controls. An interrupt-entry step pushes the return address to a stack and redirects the program counter to a fixed handler.

The block drives one single-port synchronous memory. The memory address always comes from the address register. A read issued in one cycle returns its data on `mem_rdata` in the next cycle. A level-sensitive interrupt request is only looked at when an instruction finishes, so no instruction is ever left half done. `state_o` and `instr_done` let a bench follow the sequence.

Top module: `cyc_seq`

## Requirements
- R1: While reset is held, `state_o` is 0 (fetch-address) and neither strobe is active. Reset sets PC to RESET_PC, the stack pointer to SP_INIT and interrupt enable to 0, so the first fetch read goes to RESET_PC.
- R2: Fetch has four steps. (1) MAR takes PC. (2) The next cycle reads at MAR while PC increments by one. (3) MBR captures `mem_rdata`. (4) The instruction register takes MBR. Consecutive instructions are therefore fetched from consecutive addresses.
- R3: An instruction word has the opcode in bits [15:13], the indirect flag in bit [12] and the address in bits [11:0]. The opcodes are 0 nop, 1 load, 2 store, 3 jump, 4 add, 5 interrupt-on, 6 interrupt-off and 7 nop.
- R4: When bit [12] is set, the word at the address field is read into MBR, and its low 12 bits become the operand address. This adds three cycles.
- R5: Load sets the accumulator to the word at the operand address, and add adds that word to it. Store writes the accumulator to the operand address.
- R6: Jump sets PC to the operand address, so the instruction after the jump is never fetched.
- R7: When an instruction finishes, the block enters the interrupt sequence only if `irq` is 1 and interrupt enable is 1. The enable value used is the one after that instruction's own update. Otherwise the next fetch starts, and interrupt enable is 0 after reset.
- R8: Interrupt entry takes two cycles. First, MBR takes PC and MAR takes the stack pointer. Second, MBR is written at the stack pointer, the stack pointer decrements, PC takes HANDLER_PC and interrupt enable clears. The next fetch read is at HANDLER_PC.
- R9: While `irq` stays high after entry, no new entry happens until an interrupt-on instruction completes.
- R10: After interrupt-off completes, a high `irq` is ignored.
- R11: An instruction takes 5 cycles for store, jump, nop, interrupt-on and interrupt-off, 6 cycles for load and add, and 3 more cycles when indirect. `instr_done` is high for exactly one cycle, in the instruction's last cycle. The state codes are: 0 fetch-address, 1 fetch-read, 2 fetch-capture, 3 decode, 4 indirect-read, 5 indirect-capture, 6 indirect-address, 7 execute, 8 execute-capture, 9 interrupt-save, 10 interrupt-write.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | DW (16) | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | AW (12) | Memory address (address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW (16) | Write data |
| state_o | output | 4 | Current step code |
| instr_done | output | 1 | High in the final cycle of each instruction |

## Verification
Reset is released at the start of cycle 0, and a direct load finishes 5 edges later. A direct store then ends 5 cycles after that, and an indirect add 9 cycles after that. The bench counts edges from reset release and compares the cycle of each `instr_done` against these sums. Memory writes are scored in order against a queue, so a stack write that is early, late or missing shows up as a mismatch. Interrupt-entry timing is checked by requiring that the first read after each stack write targets the handler address.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

    localparam int OP_W = 3;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR  = 4'd0,
        ST_FETCH_READ  = 4'd1,
        ST_FETCH_CAP   = 4'd2,
        ST_DECODE      = 4'd3,
        ST_IND_READ    = 4'd4,
        ST_IND_CAP     = 4'd5,
        ST_IND_ADDR    = 4'd6,
        ST_EXEC        = 4'd7,
        ST_EXEC_CAP    = 4'd8,
        ST_INT_SAVE    = 4'd9,
        ST_INT_WRITE   = 4'd10
    } seq_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_LOAD    = 3'd1,
        OP_STORE   = 3'd2,
        OP_JUMP    = 3'd3,
        OP_ADD     = 3'd4,
        OP_INT_ON  = 3'd5,
        OP_INT_OFF = 3'd6,
        OP_SPARE   = 3'd7
    } opcode_e;

endpackage

// File: rtl/cyc_seq_ctl.sv
module cyc_seq_ctl
    import cyc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  opcode_e    op,
    input  logic       ind_bit,
    input  logic       irq,
    input  logic       ien_next,
    output seq_state_e state,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       instr_done
);

    typedef struct packed {
        seq_state_e state;
    } ctl_t;

    ctl_t q, d;
    logic needs_cap;
    logic end_step;

    always_comb begin
        needs_cap = (op == OP_LOAD) || (op == OP_ADD);
        end_step  = ((q.state == ST_EXEC) && !needs_cap) || (q.state == ST_EXEC_CAP);
        d = q;
        unique case (q.state)
            ST_FETCH_ADDR: d.state = ST_FETCH_READ;
            ST_FETCH_READ: d.state = ST_FETCH_CAP;
            ST_FETCH_CAP:  d.state = ST_DECODE;
            ST_DECODE:     d.state = ind_bit ? ST_IND_READ : ST_EXEC;
            ST_IND_READ:   d.state = ST_IND_CAP;
            ST_IND_CAP:    d.state = ST_IND_ADDR;
            ST_IND_ADDR:   d.state = ST_EXEC;
            ST_EXEC:       d.state = needs_cap ? ST_EXEC_CAP : ST_FETCH_ADDR;
            ST_EXEC_CAP:   d.state = ST_FETCH_ADDR;
            ST_INT_SAVE:   d.state = ST_INT_WRITE;
            ST_INT_WRITE:  d.state = ST_FETCH_ADDR;
            default:       d.state = ST_FETCH_ADDR;
        endcase
        if (end_step && irq && ien_next) begin
            d.state = ST_INT_SAVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_FETCH_ADDR;
        end else begin
            q <= d;
        end
    end

    assign state      = q.state;
    assign instr_done = end_step;
    assign mem_rd     = (q.state == ST_FETCH_READ) || (q.state == ST_IND_READ) ||
                        ((q.state == ST_EXEC) && needs_cap);
    assign mem_wr     = (q.state == ST_INT_WRITE) ||
                        ((q.state == ST_EXEC) && (op == OP_STORE));

endmodule

// File: rtl/cyc_seq_regs.sv
module cyc_seq_regs
    import cyc_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter logic [AW-1:0] RESET_PC   = '0,
    parameter logic [AW-1:0] HANDLER_PC = '0,
    parameter logic [AW-1:0] SP_INIT    = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_e    state,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] sp,
    output opcode_e       op,
    output logic          ien,
    output logic          ien_next
);

    typedef struct packed {
        logic [AW-1:0]   pc;
        logic [AW-1:0]   mar;
        logic [DW-1:0]   mbr;
        logic [OP_W-1:0] ir;
        logic [DW-1:0]   acc;
        logic [AW-1:0]   sp;
        logic            ien;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        unique case (state)
            ST_FETCH_ADDR: d.mar = q.pc;
            ST_FETCH_READ: d.pc  = q.pc + AW'(1);
            ST_FETCH_CAP:  d.mbr = mem_rdata;
            ST_DECODE: begin
                d.ir  = q.mbr[DW-1 -: OP_W];
                d.mar = q.mbr[AW-1:0];
            end
            ST_IND_CAP:    d.mbr = mem_rdata;
            ST_IND_ADDR:   d.mar = q.mbr[AW-1:0];
            ST_EXEC: begin
                unique case (opcode_e'(q.ir))
                    OP_JUMP:    d.pc  = q.mar;
                    OP_INT_ON:  d.ien = 1'b1;
                    OP_INT_OFF: d.ien = 1'b0;
                    default:    ;
                endcase
            end
            ST_EXEC_CAP: begin
                d.mbr = mem_rdata;
                if (opcode_e'(q.ir) == OP_ADD) d.acc = q.acc + mem_rdata;
                else                           d.acc = mem_rdata;
            end
            ST_INT_SAVE: begin
                d.mbr = DW'(q.pc);
                d.mar = q.sp;
            end
            ST_INT_WRITE: begin
                d.sp  = q.sp - AW'(1);
                d.pc  = HANDLER_PC;
                d.ien = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pc  <= RESET_PC;
            q.mar <= '0;
            q.mbr <= '0;
            q.ir  <= '0;
            q.acc <= '0;
            q.sp  <= SP_INIT;
            q.ien <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pc       = q.pc;
    assign mar      = q.mar;
    assign mbr      = q.mbr;
    assign acc      = q.acc;
    assign sp       = q.sp;
    assign op       = opcode_e'(q.ir);
    assign ien      = q.ien;
    assign ien_next = d.ien;

endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
    import cyc_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] RESET_PC   = '0,
    parameter logic [AW-1:0] HANDLER_PC = 12'h800,
    parameter logic [AW-1:0] SP_INIT    = '1,
    localparam int DW = OP_W + 1 + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [3:0]    state_o,
    output logic          instr_done
);

    seq_state_e    state_w;
    opcode_e       op_w;
    logic [AW-1:0] pc_w, mar_w, sp_w;
    logic [DW-1:0] mbr_w, acc_w;
    logic          ien_w, ien_nx_w;

    cyc_seq_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op_w),
        .ind_bit    (mbr_w[AW]),
        .irq        (irq),
        .ien_next   (ien_nx_w),
        .state      (state_w),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .instr_done (instr_done)
    );

    cyc_seq_regs #(
        .AW         (AW),
        .DW         (DW),
        .RESET_PC   (RESET_PC),
        .HANDLER_PC (HANDLER_PC),
        .SP_INIT    (SP_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_w),
        .mem_rdata (mem_rdata),
        .pc        (pc_w),
        .mar       (mar_w),
        .mbr       (mbr_w),
        .acc       (acc_w),
        .sp        (sp_w),
        .op        (op_w),
        .ien       (ien_w),
        .ien_next  (ien_nx_w)
    );

    assign mem_addr  = mar_w;
    assign mem_wdata = (state_w == ST_INT_WRITE) ? mbr_w : acc_w;
    assign state_o   = state_w;

endmodule

// File: rtl/cyc_seq_chk.sv
module cyc_seq_chk
    import cyc_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] HANDLER_PC = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [3:0]    state,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          instr_done,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] sp,
    input logic          ien
);

    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r2_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_READ) |=> (pc == $past(pc) + AW'(1)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    a_r7_entry_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_SAVE) |-> $past(instr_done));

    a_r7_no_entry_without_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !irq) |=> (state != ST_INT_SAVE));

    a_r8_save_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_SAVE) |=> (mem_wr && mem_addr == $past(sp)));

    a_r8_handler_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_WRITE) |=> (pc == HANDLER_PC && !ien && sp == $past(sp) - AW'(1)));

endmodule

bind cyc_seq cyc_seq_chk #(
    .AW         (AW),
    .HANDLER_PC (HANDLER_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .state      (state_o),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .instr_done (instr_done),
    .pc         (pc_w),
    .sp         (sp_w),
    .ien        (ien_w)
);

// File: tb/tb_cyc_seq.sv
module tb_cyc_seq;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam logic [AW-1:0] HANDLER = 12'h800;
    localparam logic [AW-1:0] SP_TOP  = 12'hFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [3:0]    state_o;
    logic          instr_done;

    always #4 clk = ~clk;

    cyc_seq #(.AW(AW), .RESET_PC(12'h000), .HANDLER_PC(HANDLER), .SP_INIT(SP_TOP)) dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .state_o(state_o), .instr_done(instr_done)
    );

    logic [DW-1:0] mem [0:(1<<AW)-1];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   done_cnt = 0;
    int   done_cyc[$];
    int   rd_cnt = 0;
    int   both_cnt = 0;
    int   saves = 0;
    bit   want_handler = 1'b0;
    bit   seen_203 = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    function automatic logic [DW-1:0] enc(input int op, input bit ind, input logic [AW-1:0] a);
        return {op[2:0], ind, a};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && mem_wr) both_cnt++;
            if (mem_rd) begin
                rd_cnt++;
                if (rd_cnt == 1) check(mem_addr == 12'h000, "R1", "first fetch address", mem_addr, 0);
                if (rd_cnt == 3) check(mem_addr == 12'h001, "R2", "second fetch address", mem_addr, 1);
                if (want_handler) begin
                    check(mem_addr == HANDLER, "R8", "fetch after entry", mem_addr, HANDLER);
                    want_handler = 1'b0;
                end
            end
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected write address", mem_addr, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, e.tag, "write address", mem_addr, e.a);
                    check(mem_wdata == e.d, e.tag, "write data", mem_wdata, e.d);
                end
                if (mem_addr >= 12'hF00) begin
                    want_handler = 1'b1;
                    saves++;
                end
                if (mem_addr == 12'h203) seen_203 = 1'b1;
            end
            if (instr_done) begin
                done_cnt++;
                if (done_cyc.size() < 3) done_cyc.push_back(cyc);
            end
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        mem[12'h000] = enc(1, 1'b0, 12'h100);
        mem[12'h001] = enc(2, 1'b0, 12'h200);
        mem[12'h002] = enc(4, 1'b1, 12'h101);
        mem[12'h003] = enc(2, 1'b1, 12'h103);
        mem[12'h004] = enc(3, 1'b0, 12'h010);
        mem[12'h005] = enc(2, 1'b0, 12'h2FF);
        mem[12'h010] = enc(5, 1'b0, 12'h000);
        mem[12'h011] = enc(0, 1'b0, 12'h000);
        mem[12'h100] = 16'h1234;
        mem[12'h101] = 16'h0102;
        mem[12'h102] = 16'h0011;
        mem[12'h103] = 16'h0201;
        mem[12'h104] = 16'h0900;
        mem[12'h800] = enc(2, 1'b0, 12'h202);
        mem[12'h801] = enc(5, 1'b0, 12'h000);
        mem[12'h802] = enc(6, 1'b0, 12'h000);
        mem[12'h803] = enc(3, 1'b1, 12'h104);
        mem[12'h900] = enc(2, 1'b0, 12'h203);
        mem[12'h901] = enc(3, 1'b0, 12'h901);

        push_exp(12'h200, 16'h1234, "R3 R5 R7");
        push_exp(12'h201, 16'h1245, "R4 R5");
        push_exp(12'hFFF, 16'h0011, "R7 R8");
        push_exp(12'h202, 16'h1245, "R9");
        push_exp(12'hFFE, 16'h0802, "R8 R9");
        push_exp(12'h202, 16'h1245, "R9");
        push_exp(12'h203, 16'h1245, "R4 R6");

        irq = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(state_o == 4'd0, "R1", "state in reset", state_o, 0);
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        wait (saves == 2);
        #1 irq = 1'b0;
        wait (seen_203);
        #1 irq = 1'b1;
        begin
            int base;
            base = done_cnt;
            repeat (200) @(negedge clk);
            check(done_cnt >= base + 30, "R10", "instructions still completing", done_cnt - base, 30);
        end
        check(saves == 2, "R10", "no entry after interrupt-off", saves, 2);
        check(exp_q.size() == 0, "R5", "writes left pending", exp_q.size(), 0);
        check(done_cyc.size() == 3, "R11", "done pulses seen", done_cyc.size(), 3);
        if (done_cyc.size() == 3) begin
            check(done_cyc[0] == 5,  "R11", "direct load end cycle", done_cyc[0], 5);
            check(done_cyc[1] == 10, "R11", "direct store end cycle", done_cyc[1], 10);
            check(done_cyc[2] == 19, "R11 R4", "indirect add end cycle", done_cyc[2], 19);
        end
        check(both_cnt == 0, "R12", "read and write together", both_cnt, 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 20000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule